// File: doc/BRIEF.md
# Snoop Filter with Fewest-Owners Replacement

This block keeps a small, fully associative record of which nodes in a coherent system may hold a copy of each cache line. Each record stores a line tag, a presence vector with one bit per node, and an age rank. A coherence agent looks up an address to learn which nodes need a snoop. Snoops then go only to those nodes and are not broadcast to every node.

Node bits are set and cleared through an update port. Setting a bit for a line that has no record creates a new record. A free record is always used when one exists. When the table is full, a record is displaced, and its tag and presence vector are shown for one cycle on an eviction output so that back-invalidations can be issued. The victim is the record with the fewest set presence bits. Among records that share that lowest count, the least recently used one is taken. When a clear removes the last owner of a line, its record is released.

Top module: `snoop_filter`

## Requirements
- R1: After reset no record is valid. Every lookup misses with an all-zero presence vector, and `evValid` stays low until a displacement occurs.
- R2: `lkHit` and `lkPresence` follow `lkTag` combinationally in the same cycle. A hit returns the stored vector, where bit n means node n may hold the line. A miss returns zero.
- R3: An update with `upSet`=1 on a tracked tag ORs in bit `upNode`. An update with `upSet`=0 on a tracked tag clears that bit. Neither causes a displacement.
- R4: A set on an untracked tag while a free record exists creates a record whose vector holds only bit `upNode`. `evValid` stays low in the following cycle.
- R5: A set on an untracked tag while the table is full replaces the valid record with the fewest set presence bits. In the next cycle `evValid` is high for exactly that cycle, and `evTag`/`evPresence` carry the displaced record's tag and vector as they were before replacement.
- R6: When several records share the lowest owner count, the least recently used of them is displaced.
- R7: A lookup hit with `lkValid`=1 makes the hit record most recently used, and so does any update that reaches a record. When an update reaches a record in the same cycle, the lookup does not change recency.
- R8: A clear that leaves a record's vector all zero releases the record. Later lookups of that tag miss, and the record is free for allocation without a displacement.
- R9: A clear (`upSet`=0) on an untracked tag changes nothing and raises no eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request; a hit refreshes recency |
| lkTag | input | TAG_W | Line tag to look up |
| lkHit | output | 1 | Lookup tag is tracked |
| lkPresence | output | NODES | Presence vector of the looked-up line (zero on miss) |
| upValid | input | 1 | Update request |
| upTag | input | TAG_W | Line tag to update |
| upNode | input | $clog2(NODES) | Node whose bit is set or cleared |
| upSet | input | 1 | 1 sets the node bit, 0 clears it |
| evValid | output | 1 | One-cycle strobe for a displaced record |
| evTag | output | TAG_W | Tag of the displaced record |
| evPresence | output | NODES | Presence vector of the displaced record |

## Verification
The hardest case to reach from the ports is a full table where the fewest-owner count is shared by several records whose recency differs. Recency is visible only through which record is displaced later. The bench fills all records and raises owner counts on some of them. It then refreshes chosen tags with lookups, including a lookup in the same cycle as an update, and reads the order off the eviction port. After that, a long random run over a tag pool somewhat larger than the table keeps the table full and produces many count ties, while a reference model based on timestamps predicts every displacement.

// File: rtl/sf_pkg.sv
package sf_pkg;
  // Upper bound for entry and node index fields carried in the strobe struct.
  localparam int SfIdxW = 8;

  typedef struct packed {
    logic              wrAlloc;  // write a new tag with a single node bit
    logic              setBit;   // OR a node bit into an existing entry
    logic              clrBit;   // remove a node bit from an existing entry
    logic              evict;    // present the old entry contents on the eviction port
    logic [SfIdxW-1:0] entry;
    logic [SfIdxW-1:0] node;
  } sfStrobe_t;
endpackage

// File: rtl/sf_datapath.sv
module sf_datapath
  import sf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NODES   = 4,
  parameter int TAG_W   = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [TAG_W-1:0]                   lkTag,
  input  logic [TAG_W-1:0]                   upTag,
  input  sfStrobe_t                          strobe,
  output logic [ENTRIES-1:0]                 lkHitVec,
  output logic [ENTRIES-1:0]                 upHitVec,
  output logic [ENTRIES-1:0]                 validVec,
  output logic [ENTRIES-1:0][$clog2(NODES+1)-1:0] popCnt,
  output logic                               lkHit,
  output logic [NODES-1:0]                   lkPresence,
  output logic                               evValid,
  output logic [TAG_W-1:0]                   evTag,
  output logic [NODES-1:0]                   evPresence
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int NODE_W = $clog2(NODES);
  localparam int CNT_W  = $clog2(NODES + 1);

  logic [TAG_W-1:0] tagQ  [ENTRIES];
  logic [NODES-1:0] presQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;

  logic [IDX_W-1:0] wrIdx;
  logic [NODES-1:0] nodeBit;
  logic [NODES-1:0] clrNext;

  assign validVec = validQ;
  assign wrIdx    = strobe.entry[IDX_W-1:0];
  assign nodeBit  = NODES'(1) << strobe.node[NODE_W-1:0];
  assign clrNext  = presQ[wrIdx] & ~nodeBit;

  // Tag compare and owner count for every entry
  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign lkHitVec[i] = validQ[i] && (tagQ[i] == lkTag);
    assign upHitVec[i] = validQ[i] && (tagQ[i] == upTag);
    assign popCnt[i]   = CNT_W'($countones(presQ[i]));

    a_r8_valid_nonzero: assert property (@(posedge clk) disable iff (!rstN)
      validQ[i] |-> (presQ[i] != '0))
      else $error("R8: valid entry with empty presence vector");
  end

  always_comb begin
    lkPresence = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkHitVec[i]) lkPresence = lkPresence | presQ[i];
    end
  end
  assign lkHit = |lkHitVec;

  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkHitVec))
    else $error("R2: tag present in more than one entry");

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ     <= '0;
      evValid    <= 1'b0;
      evTag      <= '0;
      evPresence <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]  <= '0;
        presQ[i] <= '0;
      end
    end else begin
      evValid <= strobe.evict;
      if (strobe.evict) begin
        evTag      <= tagQ[wrIdx];
        evPresence <= presQ[wrIdx];
      end
      if (strobe.wrAlloc) begin
        tagQ[wrIdx]   <= upTag;
        presQ[wrIdx]  <= nodeBit;
        validQ[wrIdx] <= 1'b1;
      end else if (strobe.setBit) begin
        presQ[wrIdx] <= presQ[wrIdx] | nodeBit;
      end else if (strobe.clrBit) begin
        presQ[wrIdx] <= clrNext;
        if (clrNext == '0) validQ[wrIdx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sf_control.sv
module sf_control
  import sf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NODES   = 4
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    lkValid,
  input  logic                                    upValid,
  input  logic                                    upSet,
  input  logic [$clog2(NODES)-1:0]                upNode,
  input  logic [ENTRIES-1:0]                      lkHitVec,
  input  logic [ENTRIES-1:0]                      upHitVec,
  input  logic [ENTRIES-1:0]                      validVec,
  input  logic [ENTRIES-1:0][$clog2(NODES+1)-1:0] popCnt,
  output sfStrobe_t                               strobe
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(NODES + 1);

  // Age rank per entry: 0 is most recent, ENTRIES-1 is oldest; always a permutation.
  logic [IDX_W-1:0] rankQ [ENTRIES];

  logic             upHitAny, lkHitAny, freeAny;
  logic [IDX_W-1:0] upHitIdx, lkHitIdx, freeIdx, victimIdx;
  logic             touchEn;
  logic [IDX_W-1:0] touchIdx;

  function automatic logic [IDX_W-1:0] encode(input logic [ENTRIES-1:0] vec);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  assign upHitAny = |upHitVec;
  assign lkHitAny = |lkHitVec;
  assign freeAny  = ~&validVec;
  assign upHitIdx = encode(upHitVec);
  assign lkHitIdx = encode(lkHitVec);
  assign freeIdx  = encode(~validVec);

  // Victim: lowest owner count, then oldest rank, then lowest index
  always_comb begin
    logic             found;
    logic [CNT_W-1:0] bestPop;
    logic [IDX_W-1:0] bestRank;
    found     = 1'b0;
    bestPop   = '1;
    bestRank  = '0;
    victimIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (validVec[i]) begin
        if (!found || (popCnt[i] < bestPop) ||
            ((popCnt[i] == bestPop) && (rankQ[i] > bestRank))) begin
          found     = 1'b1;
          bestPop   = popCnt[i];
          bestRank  = rankQ[i];
          victimIdx = IDX_W'(i);
        end
      end
    end
  end

  // Operation decode
  always_comb begin
    strobe   = '0;
    touchEn  = 1'b0;
    touchIdx = '0;
    strobe.node = SfIdxW'(upNode);
    if (upValid) begin
      if (upHitAny) begin
        strobe.entry  = SfIdxW'(upHitIdx);
        strobe.setBit = upSet;
        strobe.clrBit = !upSet;
        touchEn       = 1'b1;
        touchIdx      = upHitIdx;
      end else if (upSet) begin
        strobe.wrAlloc = 1'b1;
        strobe.evict   = !freeAny;
        strobe.entry   = SfIdxW'(freeAny ? freeIdx : victimIdx);
        touchEn        = 1'b1;
        touchIdx       = freeAny ? freeIdx : victimIdx;
      end
    end
    if (!touchEn && lkValid && lkHitAny) begin
      touchEn  = 1'b1;
      touchIdx = lkHitIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) rankQ[i] <= IDX_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touchIdx)          rankQ[i] <= '0;
        else if (rankQ[i] < rankQ[touchIdx]) rankQ[i] <= rankQ[i] + 1'b1;
      end
    end
  end

  for (genvar r = 0; r < ENTRIES; r++) begin : g_rankChk
    logic [ENTRIES-1:0] holds;
    always_comb begin
      for (int i = 0; i < ENTRIES; i++) holds[i] = (rankQ[i] == IDX_W'(r));
    end
    a_r6_rank_unique: assert property (@(posedge clk) disable iff (!rstN)
      $countones(holds) == 1)
      else $error("R6: age ranks are not a permutation");
  end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
  import sf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NODES   = 4,
  parameter int TAG_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lkValid,
  input  logic [TAG_W-1:0]         lkTag,
  output logic                     lkHit,
  output logic [NODES-1:0]         lkPresence,
  input  logic                     upValid,
  input  logic [TAG_W-1:0]         upTag,
  input  logic [$clog2(NODES)-1:0] upNode,
  input  logic                     upSet,
  output logic                     evValid,
  output logic [TAG_W-1:0]         evTag,
  output logic [NODES-1:0]         evPresence
);
  localparam int CNT_W = $clog2(NODES + 1);

  sfStrobe_t                          strobe;
  logic [ENTRIES-1:0]                 lkHitVec, upHitVec, validVec;
  logic [ENTRIES-1:0][CNT_W-1:0]      popCnt;

  sf_control #(.ENTRIES(ENTRIES), .NODES(NODES)) i_control (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .upValid(upValid),
    .upSet(upSet), .upNode(upNode), .lkHitVec(lkHitVec),
    .upHitVec(upHitVec), .validVec(validVec), .popCnt(popCnt),
    .strobe(strobe)
  );

  sf_datapath #(.ENTRIES(ENTRIES), .NODES(NODES), .TAG_W(TAG_W)) i_datapath (
    .clk(clk), .rstN(rstN), .lkTag(lkTag), .upTag(upTag), .strobe(strobe),
    .lkHitVec(lkHitVec), .upHitVec(upHitVec), .validVec(validVec),
    .popCnt(popCnt), .lkHit(lkHit), .lkPresence(lkPresence),
    .evValid(evValid), .evTag(evTag), .evPresence(evPresence)
  );

  a_r3_hit_no_evict: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && (|upHitVec)) |=> !evValid)
    else $error("R3: update of tracked line raised an eviction");

  a_r4_free_no_evict: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upSet && !(|upHitVec) && !(&validVec)) |=> !evValid)
    else $error("R4: allocation with free entry raised an eviction");

  a_r5_evict_full: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upSet && !(|upHitVec) && (&validVec)) |=> (evValid && evPresence != '0))
    else $error("R5: full-table allocation without a proper eviction");

  a_r9_clear_miss: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !upSet && !(|upHitVec)) |=> (!evValid && $stable(validVec)))
    else $error("R9: clear on untracked tag had an effect");
endmodule

// File: tb/test_snoop_filter.sv
module test_snoop_filter;
  localparam int ENTRIES = 8;
  localparam int NODES   = 4;
  localparam int TAG_W   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 1'b0;
  logic [TAG_W-1:0] lkTag = '0;
  logic lkHit;
  logic [NODES-1:0] lkPresence;
  logic upValid = 1'b0;
  logic [TAG_W-1:0] upTag = '0;
  logic [1:0] upNode = '0;
  logic upSet = 1'b0;
  logic evValid;
  logic [TAG_W-1:0] evTag;
  logic [NODES-1:0] evPresence;

  always #4 clk = ~clk;

  snoop_filter #(.ENTRIES(ENTRIES), .NODES(NODES), .TAG_W(TAG_W)) i_snoop_filter (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkTag(lkTag), .lkHit(lkHit),
    .lkPresence(lkPresence), .upValid(upValid), .upTag(upTag), .upNode(upNode),
    .upSet(upSet), .evValid(evValid), .evTag(evTag), .evPresence(evPresence)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model: recency kept as timestamps
  int mTag [ENTRIES];
  int mPres [ENTRIES];
  bit mValid [ENTRIES];
  int mStamp [ENTRIES];
  int stamp = 1;

  function automatic int mFind(input int tag);
    for (int i = 0; i < ENTRIES; i++) if (mValid[i] && mTag[i] == tag) return i;
    return -1;
  endfunction

  function automatic int pop(input int v);
    int c = 0;
    for (int b = 0; b < NODES; b++) if (v[b]) c++;
    return c;
  endfunction

  function automatic bit anyValid();
    for (int i = 0; i < ENTRIES; i++) if (mValid[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check lookup, advance model, check eviction next negedge
  task automatic step(input bit lv, input int lt, input bit uv, input int ut,
                      input int node, input bit set, input string note);
    int li, ui, touched, expPres, freeI, minPop, nMin, vic;
    bit expEv;
    int expEvTag, expEvPres;
    string lbl;
    lkValid = lv; lkTag = TAG_W'(lt);
    upValid = uv; upTag = TAG_W'(ut); upNode = 2'(node); upSet = set;
    #1;
    li = mFind(lt);
    expPres = (li >= 0) ? mPres[li] : 0;
    lbl = anyValid() ? "R2" : "R1";
    chk(lkHit == (li >= 0) && int'(lkPresence) == expPres, lbl, "lookup hit/presence",
        {lkHit, lkPresence}, {(li >= 0), 4'(expPres)});
    expEv = 1'b0; expEvTag = 0; expEvPres = 0; touched = -1; lbl = "R3";
    if (uv) begin
      ui = mFind(ut);
      if (ui >= 0) begin
        if (set) mPres[ui] |= (1 << node);
        else begin
          mPres[ui] &= ~(1 << node);
          if (mPres[ui] == 0) begin mValid[ui] = 1'b0; lbl = "R8"; end
        end
        touched = ui;
      end else if (set) begin
        freeI = -1;
        for (int i = ENTRIES - 1; i >= 0; i--) if (!mValid[i]) freeI = i;
        if (freeI >= 0) begin
          lbl = "R4"; vic = freeI;
        end else begin
          minPop = NODES + 1; nMin = 0; vic = 0;
          for (int i = 0; i < ENTRIES; i++) begin
            if (pop(mPres[i]) < minPop) begin minPop = pop(mPres[i]); nMin = 1; vic = i; end
            else if (pop(mPres[i]) == minPop) begin
              nMin++;
              if (mStamp[i] < mStamp[vic]) vic = i;
            end
          end
          lbl = (nMin > 1) ? "R6" : "R5";
          expEv = 1'b1; expEvTag = mTag[vic]; expEvPres = mPres[vic];
        end
        mTag[vic] = ut; mPres[vic] = 1 << node; mValid[vic] = 1'b1;
        touched = vic;
      end else lbl = "R9";
    end
    if (touched < 0 && lv && li >= 0) touched = li;
    if (touched >= 0) begin mStamp[touched] = stamp; stamp++; end
    if (note != "") lbl = note;
    @(posedge clk);
    @(negedge clk);
    if (expEv)
      chk(evValid && int'(evTag) == expEvTag && int'(evPresence) == expEvPres, lbl,
          "eviction tag/presence", {evValid, evTag, evPresence},
          {1'b1, 16'(expEvTag), 4'(expEvPres)});
    else
      chk(!evValid, lbl, "no eviction strobe", evValid, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lt, ut;
    for (int i = 0; i < ENTRIES; i++) begin mValid[i] = 0; mPres[i] = 0; mTag[i] = 0; mStamp[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    step(1, 5, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    // R4: fill the table, one owner each
    for (int k = 1; k <= 8; k++) step(0, 0, 1, k, k % 4, 1, "R4");
    // R3: second owner on tag 1, R2 readback
    step(0, 0, 1, 1, 2, 1, "R3");
    step(1, 1, 0, 0, 0, 0, "R2");
    // R7: refresh tag 2, then full-table allocation must take tag 3
    step(1, 2, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 9, 0, 1, "R7");
    // R7: lookup of tag 4 in same cycle as an update is not a refresh
    step(1, 4, 1, 5, 3, 1, "R7");
    step(0, 0, 1, 10, 1, 1, "R7");
    // R8: clearing last owner of tag 6 frees its record
    step(0, 0, 1, 6, 2, 0, "R8");
    step(1, 6, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 11, 3, 1, "R8");
    // R9: clear on untracked tag
    step(0, 0, 1, 'h55, 1, 0, "R9");
    step(1, 'h55, 0, 0, 0, 0, "R9");
    // R5/R6: random traffic over a pool larger than the table
    void'($urandom(32'h5eed));
    for (int n = 0; n < 4000; n++) begin
      lt = 1 + ($urandom % 14);
      ut = 1 + ($urandom % 14);
      step(($urandom % 2) == 0, lt, ($urandom % 5) != 0, ut,
           $urandom % NODES, ($urandom % 10) < 7, "");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule